// File: doc/BRIEF.md
# Petri-Net Place/Transition Cell

This block holds one place and one transition of a Petri net and is meant to be tiled: the fire pulses of neighbouring cells are wired into each other's mark and unmark inputs, and the token bits of feeding places are wired into each other's transition enables. Together the tiled cells form a net controller whose marking is one bit per place. A place holds at most one token. Its transition fires when the place is marked, every extra feeding place is marked, and every external condition input matches its required polarity.

The transition's fire bit is registered on the falling clock edge. Place bits update on the rising edge from the fire bits captured half a cycle earlier. A token therefore advances at most one place per clock cycle, and each fire pulse is stable for one full cycle around the rising edge that consumes it. The initial marking comes from a parameter and is loaded by an asynchronous active-low reset.

Top module: `pn_cell`

## Requirements
- R1: While `rst_ni` is low, `ls_o` equals the `INIT_MARK` parameter and `ts_o` is 0.
- R2: At a rising edge where any bit of `set_i` is 1, `ls_o` becomes 1, even when a clear is also requested in that cycle.
- R3: At a rising edge where no bit of `set_i` is 1, `ls_o` becomes 0 if any bit of `clr_i` is 1 or `ts_o` is 1.
- R4: At a rising edge with no set, no clear and `ts_o` at 0, `ls_o` keeps its value.
- R5: At each falling edge, `ts_o` is loaded with 1 exactly when `ls_o` is 1, every bit of `pre_i` is 1, and `cond_i` matches the mask. Otherwise it is loaded with 0.
- R6: A fire pulse lasts one cycle. If `ts_o` is 1 at a rising edge and no set input is active, `ts_o` is 0 at the next rising edge, so one token cannot fire twice.
- R7: `ts_o` is never 1 at a rising edge unless `ls_o` is 1.
- R8: In a ring of three cells, each marking the next and holding one initial token, exactly one `ls_o` is high in every cycle. The token moves to the next cell in the cycle after the marked cell's condition is 1, and it does not move otherwise.
- R9: Bit i of `cond_i` matches when it equals bit i of `COND_MASK`, so a mask bit of 0 selects an active-low condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. Place updates on the rising edge, fire bit on the falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_i | input | SET_W | Fire pulses from transitions that put a token in this place |
| clr_i | input | CLR_W | Fire pulses from other transitions that take the token from this place |
| cond_i | input | COND_W | External conditions for this transition |
| pre_i | input | PRE_W | Token bits of extra places feeding this transition |
| ls_o | output | 1 | Place token bit |
| ts_o | output | 1 | Transition fire pulse |

## Verification
The embedded assertions check the place update rules on every rising edge: set priority, clear by external or own fire, and hold. They also check that a fire pulse needs a marked place and cannot repeat without re-marking. The exact falling-edge enable condition, the mask polarity and the asynchronous reset value are shown only by the bench. The bench compares a standalone cell against a behavioural model. It also checks the token walk in a three-cell ring, which the assertions cannot see because it spans several cells.

// File: rtl/pn_pkg.sv
package pn_pkg;
  typedef enum logic {
    TOK_EMPTY = 1'b0,
    TOK_HELD  = 1'b1
  } tok_e;
endpackage

// File: rtl/pn_place.sv
module pn_place
  import pn_pkg::*;
#(
  parameter bit INIT_MARK = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_any_i,
  input  logic clr_any_i,
  input  logic ts_i,
  output logic ls_o
);
  localparam tok_e InitTok = INIT_MARK ? TOK_HELD : TOK_EMPTY;

  tok_e tok_q, tok_d;

  always_comb begin
    tok_d = tok_q;
    if (set_any_i)               tok_d = TOK_HELD;   // set wins
    else if (clr_any_i || ts_i)  tok_d = TOK_EMPTY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tok_q <= InitTok;
    else         tok_q <= tok_d;
  end

  assign ls_o = (tok_q == TOK_HELD);

  assert_set_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_any_i |=> ls_o);
  assert_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_any_i && (clr_any_i || ts_i)) |=> !ls_o);
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_any_i && !clr_any_i && !ts_i) |=> $stable(ls_o));
endmodule

// File: rtl/pn_trans.sv
module pn_trans #(
  parameter int unsigned        COND_W    = 1,
  parameter int unsigned        PRE_W     = 1,
  parameter logic [COND_W-1:0]  COND_MASK = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ls_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [PRE_W-1:0]  pre_i,
  output logic              ts_o
);
  logic [COND_W-1:0] match;
  logic              enable;
  logic              ts_q;

  for (genvar i = 0; i < COND_W; i++) begin : g_match
    if (COND_MASK[i]) begin : g_hi
      assign match[i] = cond_i[i];
    end else begin : g_lo
      assign match[i] = ~cond_i[i];
    end
  end

  assign enable = ls_i && (&match) && (&pre_i);

  // captured on falling edge, consumed on next rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ts_q <= 1'b0;
    else         ts_q <= enable;
  end

  assign ts_o = ts_q;

  assert_fire_needs_token_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_o |-> ls_i);
endmodule

// File: rtl/pn_cell.sv
module pn_cell #(
  parameter int unsigned        SET_W     = 1,
  parameter int unsigned        CLR_W     = 1,
  parameter int unsigned        COND_W    = 1,
  parameter int unsigned        PRE_W     = 1,
  parameter logic [COND_W-1:0]  COND_MASK = '1,
  parameter bit                 INIT_MARK = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  set_i,
  input  logic [CLR_W-1:0]  clr_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic [PRE_W-1:0]  pre_i,
  output logic              ls_o,
  output logic              ts_o
);
  logic set_any, clr_any, ls, ts;

  assign set_any = |set_i;
  assign clr_any = |clr_i;

  pn_place #(.INIT_MARK(INIT_MARK)) u_place (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_any_i(set_any),
    .clr_any_i(clr_any),
    .ts_i     (ts),
    .ls_o     (ls)
  );

  pn_trans #(.COND_W(COND_W), .PRE_W(PRE_W), .COND_MASK(COND_MASK)) u_trans (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ls_i  (ls),
    .cond_i(cond_i),
    .pre_i (pre_i),
    .ts_o  (ts)
  );

  assign ls_o = ls;
  assign ts_o = ts;

  assert_single_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_o && !(|set_i)) |=> !ts_o);
endmodule

// File: tb/pn_cell_tb_top.sv
`timescale 1ns/1ps
module pn_cell_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  int tests = 0;
  int fails = 0;

  // three-cell ring
  logic [2:0] r_cond = '0;
  logic [2:0] r_ls, r_ts;
  for (genvar g = 0; g < 3; g++) begin : g_ring
    pn_cell #(.SET_W(1), .CLR_W(1), .COND_W(1), .PRE_W(1),
              .COND_MASK(1'b1), .INIT_MARK(g == 0)) dut_i (
      .clk_i(clk), .rst_ni(rst_ni),
      .set_i(r_ts[(g+2)%3]), .clr_i(1'b0),
      .cond_i(r_cond[g]), .pre_i(1'b1),
      .ls_o(r_ls[g]), .ts_o(r_ts[g])
    );
  end

  // standalone cell, cond[0] active-high, cond[1] active-low
  logic [1:0] s_set = '0, s_clr = '0, s_cond = '0, s_pre = '0;
  logic s_ls, s_ts;
  pn_cell #(.SET_W(2), .CLR_W(2), .COND_W(2), .PRE_W(2),
            .COND_MASK(2'b01), .INIT_MARK(1'b0)) solo_i (
    .clk_i(clk), .rst_ni(rst_ni), .set_i(s_set), .clr_i(s_clr),
    .cond_i(s_cond), .pre_i(s_pre), .ls_o(s_ls), .ts_o(s_ts)
  );

  // reference state
  int   tok = 0;
  logic [2:0] r_ets = '0;
  logic m_ls = 1'b0, m_ts = 1'b0;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [2:0] rc, input logic [1:0] ss, input logic [1:0] sc,
                      input logic [1:0] sd, input logic [1:0] sp);
    @(posedge clk);
    // rising-edge model update with inputs held over the last cycle
    if (r_ets != 0) tok = (tok + 1) % 3;
    if (|s_set)                m_ls = 1'b1;
    else if ((|s_clr) || m_ts) m_ls = 1'b0;
    #1;
    r_cond = rc; s_set = ss; s_clr = sc; s_cond = sd; s_pre = sp;
    @(negedge clk);
    r_ets = r_cond[tok] ? (3'b001 << tok) : 3'b000;
    m_ts  = m_ls && s_cond[0] && !s_cond[1] && (&s_pre);
    #1;
    chk("R8 ring ls", {1'b0, r_ls}, {1'b0, 3'(3'b001 << tok)});
    chk("R8 ring one-hot", 4'($countones(r_ls)), 4'd1);
    chk("R5 ring ts", {1'b0, r_ts}, {1'b0, r_ets});
    chk("R2 R3 R4 solo ls", {3'b0, s_ls}, {3'b0, m_ls});
    chk("R5 R6 R9 solo ts", {3'b0, s_ts}, {3'b0, m_ts});
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog R8: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 ring ls", {1'b0, r_ls}, 4'b0001);
    chk("R1 ring ts", {1'b0, r_ts}, 4'b0000);
    chk("R1 solo ls", {3'b0, s_ls}, 4'b0000);
    chk("R1 solo ts", {3'b0, s_ts}, 4'b0000);
    @(posedge clk); #1 rst_ni = 1'b1;
    @(negedge clk); #1;

    // hold: no conditions, no move (R8, R4)
    repeat (4) step(3'b000, 2'b00, 2'b00, 2'b01, 2'b11);
    // conditions on non-token cells only
    repeat (3) step(3'b110, 2'b00, 2'b00, 2'b01, 2'b11);
    // all conditions high: one move per cycle
    repeat (7) step(3'b111, 2'b00, 2'b00, 2'b01, 2'b11);
    step(3'b000, 2'b00, 2'b00, 2'b00, 2'b00);

    // solo: mark, wrong polarity on cond[1] blocks fire (R9)
    step(3'b000, 2'b01, 2'b00, 2'b11, 2'b11);
    repeat (2) step(3'b000, 2'b00, 2'b00, 2'b11, 2'b11);
    // cond[0] low blocks fire (R9)
    step(3'b000, 2'b00, 2'b00, 2'b00, 2'b11);
    // one extra place empty blocks fire (R5)
    step(3'b000, 2'b00, 2'b00, 2'b01, 2'b10);
    // all enabled: fires once, token consumed (R5, R3, R6)
    repeat (3) step(3'b000, 2'b00, 2'b00, 2'b01, 2'b11);
    // set and clear together: set wins (R2)
    step(3'b000, 2'b10, 2'b01, 2'b00, 2'b00);
    step(3'b000, 2'b00, 2'b00, 2'b00, 2'b00);
    // external clear alone (R3)
    step(3'b000, 2'b00, 2'b10, 2'b00, 2'b00);
    step(3'b000, 2'b00, 2'b00, 2'b00, 2'b00);
    // re-mark during fire keeps token and fires again (R2, R6)
    step(3'b000, 2'b01, 2'b00, 2'b01, 2'b11);
    step(3'b000, 2'b01, 2'b00, 2'b01, 2'b11);
    repeat (3) step(3'b000, 2'b00, 2'b00, 2'b01, 2'b11);

    // random mix
    for (int i = 0; i < 300; i++)
      step(3'($urandom % 8), 2'($urandom % 4), ($urandom % 5 == 0) ? 2'b01 : 2'b00,
           2'($urandom % 4), ($urandom % 3 == 0) ? 2'b01 : 2'b11);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule